// File: doc/BRIEF.md
# Time-of-Day Calendar Counter with Alarm

This block keeps wall-clock time and calendar date in a set of registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle `tick_1hz` enable advances the time by one second, with carries through every field. Day-of-month rollover follows the length of each month and gives February 29 days in leap years. A separate microsecond phase input tells the block where it is within the current second. From this it raises an update-busy flag just before each second boundary.

Software-visible fields are written and read one byte at a time through a small select/data port. Each byte is encoded in either packed BCD or plain binary, and hours are shown in 24-hour or 12-hour form, as chosen by the control byte. Internally the counters are always binary, so a format change takes effect on the next read. A hold bit freezes the clock while software loads a new time.

After each counted second the block emits an update-done pulse. One cycle later it compares the new time with three alarm bytes, any of which can be made a wildcard, and emits an alarm pulse on a match.

Top module: `rtc_tod_counter`

## Requirements
- R1: After reset the time reads 00:00:00 with weekday 1, date 1, month 1 and year 0. The control byte reads 0x04. `update_busy`, `update_done` and `alarm_hit` are all low. Select map: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours, 10 control. Control bits: bit 0 is hold, bit 1 is binary format, bit 2 is 24-hour mode.
- R2: With control bit 1 clear, field bytes are written and read as BCD (tens digit in bits 7:4, units in bits 3:0). With the bit set they are plain binary. A value written in one format reads back correctly in the other.
- R3: With control bit 2 clear, hours are shown as 1..12 with bit 7 set for PM. Internal hour 0 reads as 12 AM and hours 12..23 read with bit 7 set. Writes in that mode decode the same way.
- R4: A `tick_1hz` cycle, when hold is clear and no write occurs in the same cycle, advances the seconds. The carry passes through minutes, hours and weekday (7 wraps to 1). `update_done` is high for exactly the cycle after that tick.
- R5: The date rolls to 1 after the last day of the month. That last day is the 30th for months 4, 6, 9 and 11, the 31st for the other months, and for February the 29th when the binary year is divisible by 4, else the 28th. Month 12 wraps to 1, and year 99 wraps to 0.
- R6: `update_busy` is high exactly when hold is clear and `phase_us` is at least 999756, which is the last 244 µs of the second.
- R7: While hold is set, ticks do not change the time, `update_done` and `alarm_hit` stay low, and `update_busy` is low.
- R8: `alarm_hit` pulses in the cycle after `update_done` when the updated seconds, minutes and hours all equal their alarm bytes, decoded in the current format. It stays low otherwise.
- R9: An alarm byte with bits 7 and 6 both set matches any value of its field.
- R10: A write changes only the addressed field; other fields read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle enable marking a second boundary |
| phase_us | input | 20 | Microseconds elapsed in the current second |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 4 | Field selected for writing |
| wr_data | input | 8 | Encoded byte to write |
| rd_sel | input | 4 | Field selected for reading |
| rd_data | output | 8 | Encoded byte of the selected field |
| update_busy | output | 1 | Update-in-progress flag |
| update_done | output | 1 | One-cycle pulse after each counted second |
| alarm_hit | output | 1 | One-cycle alarm pulse |

## Verification
The hardest case to reach from the ports is a full calendar cascade: a single tick that carries out of seconds, minutes, hours, date, month and year at once, together with the leap-year February boundaries. The stimulus writes every field to the last value before the carry while the clock is otherwise idle, then issues one tick and reads back all fields. The 12-hour alarm decode is reached the same way, by loading the time one second before a PM match.

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter #(
  parameter int unsigned US_PER_SEC = 1000000,
  parameter int unsigned UIP_US     = 244,
  parameter int unsigned PHASE_W    = $clog2(US_PER_SEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_1hz,
  input  logic [PHASE_W-1:0] phase_us,
  input  logic               wr_en,
  input  logic [3:0]         wr_sel,
  input  logic [7:0]         wr_data,
  input  logic [3:0]         rd_sel,
  output logic [7:0]         rd_data,
  output logic               update_busy,
  output logic               update_done,
  output logic               alarm_hit
);
  localparam int unsigned BUSY_FROM = US_PER_SEC - UIP_US;
  localparam logic [3:0] F_SEC = 4'd0, F_MIN = 4'd1, F_HOUR = 4'd2, F_WDAY = 4'd3,
                         F_DAY = 4'd4, F_MON = 4'd5, F_YEAR = 4'd6,
                         F_ASEC = 4'd7, F_AMIN = 4'd8, F_AHOUR = 4'd9, F_CTRL = 4'd10;

  logic [5:0] sec_q, min_q;
  logic [4:0] hour_q, day_q;
  logic [2:0] wday_q;
  logic [3:0] mon_q;
  logic [6:0] year_q;
  logic [7:0] asec_q, amin_q, ahour_q;
  logic       hold_q, bin_q, h24_q;
  logic       done_q, pend_q, alarm_q;

  function automatic logic [6:0] dec(input logic [7:0] raw, input logic bin);
    int t, u;
    t = int'(raw[7:4]);
    u = int'(raw[3:0]);
    return bin ? raw[6:0] : 7'(t * 10 + u);
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    int t, u;
    t = int'(v) / 10;
    u = int'(v) % 10;
    return bin ? {1'b0, v} : {4'(t), 4'(u)};
  endfunction

  function automatic logic [4:0] hour_in(input logic [7:0] raw, input logic bin, input logic h24);
    int h;
    h = int'(dec({1'b0, raw[6:0]}, bin));
    if (!h24) h = (h % 12) + (raw[7] ? 12 : 0);
    return 5'(h);
  endfunction

  function automatic logic [7:0] hour_out(input logic [4:0] h, input logic bin, input logic h24);
    int h12;
    if (h24) return enc({2'b0, h}, bin);
    h12 = (int'(h) % 12 == 0) ? 12 : int'(h) % 12;
    return enc(7'(h12), bin) | ((h >= 5'd12) ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                   return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction

  wire step = tick_1hz && !hold_q && !wr_en;

  wire wild_s = asec_q[7:6] == 2'b11;
  wire wild_m = amin_q[7:6] == 2'b11;
  wire wild_h = ahour_q[7:6] == 2'b11;
  wire hit_s  = wild_s || (dec(asec_q, bin_q) == {1'b0, sec_q});
  wire hit_m  = wild_m || (dec(amin_q, bin_q) == {1'b0, min_q});
  wire hit_h  = wild_h || (hour_in(ahour_q, bin_q, h24_q) == hour_q);

  assign update_busy = !hold_q && (phase_us >= PHASE_W'(BUSY_FROM));
  assign update_done = done_q;
  assign alarm_hit   = alarm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hour_q <= '0;
      wday_q <= 3'd1; day_q <= 5'd1; mon_q <= 4'd1; year_q <= '0;
      asec_q <= '0; amin_q <= '0; ahour_q <= '0;
      hold_q <= 1'b0; bin_q <= 1'b0; h24_q <= 1'b1;
    end else if (wr_en) begin
      case (wr_sel)
        F_SEC:   sec_q   <= 6'(dec(wr_data, bin_q));
        F_MIN:   min_q   <= 6'(dec(wr_data, bin_q));
        F_HOUR:  hour_q  <= hour_in(wr_data, bin_q, h24_q);
        F_WDAY:  wday_q  <= 3'(dec(wr_data, bin_q));
        F_DAY:   day_q   <= 5'(dec(wr_data, bin_q));
        F_MON:   mon_q   <= 4'(dec(wr_data, bin_q));
        F_YEAR:  year_q  <= dec(wr_data, bin_q);
        F_ASEC:  asec_q  <= wr_data;
        F_AMIN:  amin_q  <= wr_data;
        F_AHOUR: ahour_q <= wr_data;
        F_CTRL:  {h24_q, bin_q, hold_q} <= wr_data[2:0];
        default: ;
      endcase
    end else if (step) begin
      if (sec_q < 6'd59) sec_q <= sec_q + 6'd1;
      else begin
        sec_q <= '0;
        if (min_q < 6'd59) min_q <= min_q + 6'd1;
        else begin
          min_q <= '0;
          if (hour_q < 5'd23) hour_q <= hour_q + 5'd1;
          else begin
            hour_q <= '0;
            wday_q <= (wday_q >= 3'd7) ? 3'd1 : wday_q + 3'd1;
            if (day_q < month_len(mon_q, year_q)) day_q <= day_q + 5'd1;
            else begin
              day_q <= 5'd1;
              if (mon_q < 4'd12) mon_q <= mon_q + 4'd1;
              else begin
                mon_q  <= 4'd1;
                year_q <= (year_q >= 7'd99) ? 7'd0 : year_q + 7'd1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; pend_q <= 1'b0; alarm_q <= 1'b0;
    end else begin
      done_q  <= step;
      pend_q  <= step;
      alarm_q <= pend_q && !hold_q && hit_s && hit_m && hit_h;
    end
  end

  always_comb begin
    case (rd_sel)
      F_SEC:   rd_data = enc({1'b0, sec_q}, bin_q);
      F_MIN:   rd_data = enc({1'b0, min_q}, bin_q);
      F_HOUR:  rd_data = hour_out(hour_q, bin_q, h24_q);
      F_WDAY:  rd_data = enc({4'b0, wday_q}, bin_q);
      F_DAY:   rd_data = enc({2'b0, day_q}, bin_q);
      F_MON:   rd_data = enc({3'b0, mon_q}, bin_q);
      F_YEAR:  rd_data = enc(year_q, bin_q);
      F_ASEC:  rd_data = asec_q;
      F_AMIN:  rd_data = amin_q;
      F_AHOUR: rd_data = ahour_q;
      F_CTRL:  rd_data = {5'b0, h24_q, bin_q, hold_q};
      default: rd_data = 8'h00;
    endcase
  end

  assert_done_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !hold_q && !wr_en) |=> update_done);
  assert_sec_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !hold_q && !wr_en) |=> (sec_q == 6'd0 || sec_q == $past(sec_q) + 6'd1));
  assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (!update_done && !alarm_hit));
  assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !wr_en) |=> $stable(sec_q));
  assert_alarm_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> $past(update_done));
endmodule

// File: tb/rtc_tod_counter_tb.sv
module rtc_tod_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [19:0] phase = '0;
  logic wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic busy, done, alarm;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rtc_tod_counter dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .phase_us(phase),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .update_busy(busy), .update_done(done), .alarm_hit(alarm)
  );

  // {ctrl at write, select, byte written, ctrl at read, expected byte}
  localparam logic [35:0] VEC [10] = '{
    {8'h04, 4'd2, 8'h23, 8'h04, 8'h23},
    {8'h04, 4'd2, 8'h23, 8'h00, 8'h91},
    {8'h00, 4'd2, 8'h12, 8'h04, 8'h00},
    {8'h00, 4'd2, 8'h92, 8'h04, 8'h12},
    {8'h06, 4'd1, 8'h2D, 8'h04, 8'h45},
    {8'h04, 4'd0, 8'h59, 8'h06, 8'h3B},
    {8'h02, 4'd2, 8'h81, 8'h06, 8'h0D},
    {8'h06, 4'd2, 8'h00, 8'h02, 8'h0C},
    {8'h04, 4'd6, 8'h99, 8'h06, 8'h63},
    {8'h04, 4'd5, 8'h12, 8'h02, 8'h0C}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic pulse(output logic d, output logic a);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; d = done;
    @(negedge clk); a = alarm;
  endtask

  task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    logic d, a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0, v); chk("R1 sec", v, 8'h00);
    rd(4'd2, v); chk("R1 hour", v, 8'h00);
    rd(4'd3, v); chk("R1 wday", v, 8'h01);
    rd(4'd4, v); chk("R1 date", v, 8'h01);
    rd(4'd5, v); chk("R1 month", v, 8'h01);
    rd(4'd10, v); chk("R1 ctrl", v, 8'h04);
    chk("R1 flags", {5'b0, busy, done, alarm}, 8'h00);

    // R2 / R3 format vectors
    for (int i = 0; i < 10; i++) begin
      wr(4'd10, VEC[i][35:28]);
      wr(VEC[i][27:24], VEC[i][23:16]);
      wr(4'd10, VEC[i][15:8]);
      rd(VEC[i][27:24], v);
      chk((VEC[i][27:24] == 4'd2) ? "R3 hour format" : "R2 encoding", v, VEC[i][7:0]);
    end

    // R10 field isolation
    wr(4'd10, 8'h04);
    wr(4'd1, 8'h17);
    wr(4'd2, 8'h08);
    rd(4'd1, v); chk("R10 min kept", v, 8'h17);
    rd(4'd2, v); chk("R10 hour", v, 8'h08);

    // R4 / R5 full cascade
    wr(4'd3, 8'h07); wr(4'd4, 8'h31); wr(4'd5, 8'h12); wr(4'd6, 8'h99);
    set_hms(8'h23, 8'h59, 8'h59);
    pulse(d, a);
    chk("R4 done pulse", {7'b0, d}, 8'h01);
    chk("R4 done one cycle", {7'b0, done}, 8'h00);
    rd(4'd0, v); chk("R4 sec wrap", v, 8'h00);
    rd(4'd1, v); chk("R4 min wrap", v, 8'h00);
    rd(4'd2, v); chk("R4 hour wrap", v, 8'h00);
    rd(4'd3, v); chk("R4 wday wrap", v, 8'h01);
    rd(4'd4, v); chk("R5 date wrap", v, 8'h01);
    rd(4'd5, v); chk("R5 month wrap", v, 8'h01);
    rd(4'd6, v); chk("R5 year wrap", v, 8'h00);
    set_hms(8'h12, 8'h34, 8'h56);
    pulse(d, a);
    rd(4'd0, v); chk("R4 sec step", v, 8'h57);

    // R5 leap year
    wr(4'd6, 8'h24); wr(4'd5, 8'h02); wr(4'd4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h59); pulse(d, a);
    rd(4'd4, v); chk("R5 leap feb 29", v, 8'h29);
    set_hms(8'h23, 8'h59, 8'h59); pulse(d, a);
    rd(4'd4, v); chk("R5 leap end date", v, 8'h01);
    rd(4'd5, v); chk("R5 leap end month", v, 8'h03);
    wr(4'd6, 8'h23); wr(4'd5, 8'h02); wr(4'd4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h59); pulse(d, a);
    rd(4'd4, v); chk("R5 common feb date", v, 8'h01);
    rd(4'd5, v); chk("R5 common feb month", v, 8'h03);
    wr(4'd5, 8'h04); wr(4'd4, 8'h30);
    set_hms(8'h23, 8'h59, 8'h59); pulse(d, a);
    rd(4'd5, v); chk("R5 april end", v, 8'h05);
    wr(4'd5, 8'h01); wr(4'd4, 8'h30);
    set_hms(8'h23, 8'h59, 8'h59); pulse(d, a);
    rd(4'd4, v); chk("R5 jan 31", v, 8'h31);

    // R6 busy window
    phase = 20'd999755; #1; chk("R6 before window", {7'b0, busy}, 8'h00);
    phase = 20'd999756; #1; chk("R6 window start", {7'b0, busy}, 8'h01);
    phase = 20'd999999; #1; chk("R6 window end", {7'b0, busy}, 8'h01);
    phase = 20'd0; #1; chk("R6 new second", {7'b0, busy}, 8'h00);

    // R8 / R9 alarm
    wr(4'd7, 8'h05); wr(4'd8, 8'hC0); wr(4'd9, 8'hC0);
    set_hms(8'h10, 8'h20, 8'h04); pulse(d, a);
    chk("R9 sec match wild min/hour", {6'b0, d, a}, 8'h03);
    pulse(d, a); chk("R8 no match next sec", {7'b0, a}, 8'h00);
    wr(4'd7, 8'hC0); pulse(d, a);
    chk("R9 all wildcard", {7'b0, a}, 8'h01);
    wr(4'd7, 8'h00); wr(4'd8, 8'h30); wr(4'd9, 8'h11);
    set_hms(8'h11, 8'h29, 8'h59); pulse(d, a);
    chk("R8 full match", {7'b0, a}, 8'h01);
    wr(4'd9, 8'h12);
    set_hms(8'h11, 8'h29, 8'h59); pulse(d, a);
    chk("R8 hour mismatch", {7'b0, a}, 8'h00);
    wr(4'd10, 8'h00);
    wr(4'd7, 8'h00); wr(4'd8, 8'hC0); wr(4'd9, 8'h81);
    set_hms(8'h81, 8'h05, 8'h59); pulse(d, a);
    chk("R8 12-hour PM alarm", {7'b0, a}, 8'h01);

    // R7 hold
    wr(4'd10, 8'h05);
    wr(4'd7, 8'hC0); wr(4'd8, 8'hC0); wr(4'd9, 8'hC0);
    wr(4'd0, 8'h30);
    pulse(d, a);
    chk("R7 no done/alarm", {6'b0, d, a}, 8'h00);
    rd(4'd0, v); chk("R7 sec frozen", v, 8'h30);
    phase = 20'd999900; #1;
    chk("R7 busy low", {7'b0, busy}, 8'h00);
    wr(4'd10, 8'h04); #1;
    chk("R6 busy after release", {7'b0, busy}, 8'h01);

    summary();
  end
endmodule